// File: doc/BRIEF.md
# Legacy Interrupt Status and Enable Register

This block is one 32-bit control word inside a host bridge that gathers four level-sensitive legacy interrupt lines (A to D) and eight bus error conditions. It raises one combined interrupt request toward a parent interrupt controller. The same word also holds unrelated bridge settings: seven request-line priority flags and a four-bit target-ready wait value. The block stores these settings, but they have no effect on its behaviour.

Software reads the word to see which lines are pending. It acknowledges a line by writing a one to that line's pending bit, and it opens or closes each source with an enable bit. Each error condition is a level that its own source holds. It reaches the combined request only through its enable bit and has no pending bit of its own. Writes carry one enable per byte lane, so a halfword write touches only its two lanes.

Top module: `intx_ctl_reg`

## Requirements
- R1: After a clock edge with `rst_n` low, `rd_data` reads 0 and `irq_out` is 0.
- R2: When `intx_in[n]` is high at a clock edge, pending bit 28+n (bit 28 = line A) reads 1 after that edge, whatever the state of the enables.
- R3: A write whose lane 3 enable is set clears each pending bit 31..28 whose `wr_data` bit is 1. Pending bits written with 0 keep their value.
- R4: If a line's input is high in the same cycle as a clear of its pending bit, the bit stays 1.
- R5: Bits 25..22 are read/write enables for lines D..A (line n at bit 22+n). `irq_out` is high whenever a pending bit and its enable are both 1.
- R6: Bits 27, 26 and 21..16 are read/write enables for `err_in[7]`, `err_in[6]` and `err_in[5:0]`. `irq_out` also goes high, in the same cycle, when an error input and its enable are both 1, and is low when no source qualifies.
- R7: `wr_be[k]` selects bits 8k+7..8k. Bits in lanes that are not selected, and all bits when `wr_en` is low, keep their value.
- R8: A write with `wr_be` = 4'b1100 and `wr_data[31:16]` = 16'hF000 clears all four pending bits and all enables in bits 27..16 (inputs low).
- R9: Bits 14..8 (priority flags) and 3..0 (wait value) are read/write and have no effect on `irq_out`.
- R10: Bits 15 and 7..4 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte-lane write enables, bit k for bits 8k+7..8k |
| wr_data | input | 32 | Write data |
| intx_in | input | 4 | Level interrupt lines, bit 0 = line A |
| err_in | input | 8 | Error condition levels from their sources |
| rd_data | output | 32 | Current register contents |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two functions can act on one pending bit in the same cycle: an acknowledge write and a new assertion of the line's input. The bench holds a line high across a clearing write, as in R4. Its randomised phase also overlaps writes with random input levels, so acknowledge and set coincide often. A behavioural model gives setting priority over clearing and is compared with the register and the request output every cycle. If the set loses, the word reads 0 one cycle early, and that mismatch is reported.

// File: rtl/intx_reg_pkg.sv
// Field layout of the interrupt status/enable word and helpers.
// Assumes a 32-bit word split into four byte lanes.
package intx_reg_pkg;
    localparam int REG_W       = 32;
    localparam int NUM_LANES   = REG_W / 8;
    localparam int NUM_LINES   = 4;
    localparam int ERR_HI_W    = 2;
    localparam int ERR_LO_W    = 6;
    localparam int NUM_ERR     = ERR_HI_W + ERR_LO_W;
    localparam int PRIO_W      = 7;
    localparam int WAIT_W      = 4;
    localparam int STS_LSB     = 28;
    localparam int ERR_HI_LSB  = 26;
    localparam int LINE_EN_LSB = 22;
    localparam int ERR_LO_LSB  = 16;
    localparam int PRIO_LSB    = 8;
    localparam int WAIT_LSB    = 0;

    // Expands byte-lane enables into per-bit write enables.
    function automatic logic [REG_W-1:0] lanes_to_bits(input logic [NUM_LANES-1:0] be);
        logic [REG_W-1:0] bits;
        for (int i = 0; i < REG_W; i++) begin
            bits[i] = be[i / 8];
        end
        return bits;
    endfunction
endpackage

// File: rtl/intx_status_bank.sv
// Pending flags for level-sensitive lines.
// Setting from a high input has priority over a write-one clear.
module intx_status_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pending
);
    for (genvar g = 0; g < N; g++) begin : g_line
        // Capture one line: set while high, otherwise clear on request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pending[g] <= 1'b0;
            end else begin
                pending[g] <= level_in[g] | (pending[g] & ~clr[g]);
            end
        end
    end
endmodule

// File: rtl/intx_cfg_field.sv
// A plain read/write field with per-bit write enables.
// Assumes the caller has already sliced data and enables to the field.
module intx_cfg_field #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Update only the bits whose enable is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            for (int i = 0; i < W; i++) begin
                if (we[i]) q[i] <= d[i];
            end
        end
    end
endmodule

// File: rtl/intx_irq_merge.sv
// Combines qualified line pending flags and error levels into one request.
// Error levels are assumed to be held by their sources until serviced.
module intx_irq_merge #(
    parameter int NL = 4,
    parameter int NE = 8
) (
    input  logic [NL-1:0] pending,
    input  logic [NL-1:0] line_en,
    input  logic [NE-1:0] err_lvl,
    input  logic [NE-1:0] err_en,
    output logic          irq
);
    // OR of every enabled, active source.
    always_comb begin
        irq = |(pending & line_en) | |(err_lvl & err_en);
    end
endmodule

// File: rtl/intx_ctl_reg.sv
// Interrupt status/enable control word: pending capture, write-one-to-clear,
// enables, stored bridge settings and the combined request output.
// Assumes single-cycle byte-lane writes; reads are the live register value.
module intx_ctl_reg
    import intx_reg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [NUM_LANES-1:0] wr_be,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [NUM_LINES-1:0] intx_in,
    input  logic [NUM_ERR-1:0]   err_in,
    output logic [REG_W-1:0]     rd_data,
    output logic                 irq_out
);
    logic [REG_W-1:0]     bit_we;
    logic [NUM_LINES-1:0] sts_clr;
    logic [NUM_LINES-1:0] pending;
    logic [NUM_LINES-1:0] line_en;
    logic [ERR_HI_W-1:0]  err_en_hi;
    logic [ERR_LO_W-1:0]  err_en_lo;
    logic [PRIO_W-1:0]    prio_q;
    logic [WAIT_W-1:0]    wait_q;
    logic                 rsvd_unused;

    // Per-bit write enables from the strobe and lane enables.
    always_comb begin
        bit_we = wr_en ? lanes_to_bits(wr_be) : '0;
    end

    // Write-one-to-clear requests for the pending bits.
    always_comb begin
        sts_clr = bit_we[STS_LSB +: NUM_LINES] & wr_data[STS_LSB +: NUM_LINES];
    end

    // Reserved positions carry no state.
    assign rsvd_unused = ^{bit_we[15], bit_we[7:4], wr_data[15], wr_data[7:4]};

    intx_status_bank #(.N(NUM_LINES)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (intx_in),
        .clr      (sts_clr),
        .pending  (pending)
    );

    intx_cfg_field #(.W(NUM_LINES)) u_line_en (
        .clk (clk), .rst_n (rst_n),
        .we  (bit_we[LINE_EN_LSB +: NUM_LINES]),
        .d   (wr_data[LINE_EN_LSB +: NUM_LINES]),
        .q   (line_en)
    );

    intx_cfg_field #(.W(ERR_HI_W)) u_err_hi (
        .clk (clk), .rst_n (rst_n),
        .we  (bit_we[ERR_HI_LSB +: ERR_HI_W]),
        .d   (wr_data[ERR_HI_LSB +: ERR_HI_W]),
        .q   (err_en_hi)
    );

    intx_cfg_field #(.W(ERR_LO_W)) u_err_lo (
        .clk (clk), .rst_n (rst_n),
        .we  (bit_we[ERR_LO_LSB +: ERR_LO_W]),
        .d   (wr_data[ERR_LO_LSB +: ERR_LO_W]),
        .q   (err_en_lo)
    );

    intx_cfg_field #(.W(PRIO_W)) u_prio (
        .clk (clk), .rst_n (rst_n),
        .we  (bit_we[PRIO_LSB +: PRIO_W]),
        .d   (wr_data[PRIO_LSB +: PRIO_W]),
        .q   (prio_q)
    );

    intx_cfg_field #(.W(WAIT_W)) u_wait (
        .clk (clk), .rst_n (rst_n),
        .we  (bit_we[WAIT_LSB +: WAIT_W]),
        .d   (wr_data[WAIT_LSB +: WAIT_W]),
        .q   (wait_q)
    );

    intx_irq_merge #(.NL(NUM_LINES), .NE(NUM_ERR)) u_merge (
        .pending (pending),
        .line_en (line_en),
        .err_lvl (err_in),
        .err_en  ({err_en_hi, err_en_lo}),
        .irq     (irq_out)
    );

    // Assemble the read view; reserved positions are zero.
    always_comb begin
        rd_data = {pending, err_en_hi, line_en, err_en_lo,
                   1'b0, prio_q, 4'b0000, wait_q};
    end
endmodule

// File: rtl/intx_ctl_reg_chk.sv
// Port-level properties of the interrupt control word, bound to the top.
module intx_ctl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  wr_be,
    input logic [31:0] wr_data,
    input logic [3:0]  intx_in,
    input logic [7:0]  err_in,
    input logic [31:0] rd_data,
    input logic        irq_out
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 32'h0 && !irq_out));

    // R2
    level_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intx_in != 4'h0) |=> ((rd_data[31:28] & $past(intx_in)) == $past(intx_in)));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[3] && intx_in == 4'h0)
        |=> (rd_data[31:28] == ($past(rd_data[31:28]) & ~$past(wr_data[31:28]))));

    // R5
    line_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data[31:28] & rd_data[25:22]) != 4'h0) |-> irq_out);

    // R6
    no_spurious_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (((rd_data[31:28] & rd_data[25:22]) != 4'h0) ||
                     ((err_in & {rd_data[27:26], rd_data[21:16]}) != 8'h0)));

    // R7
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data[27:0]));

    // R8
    half_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be == 4'b1100 && wr_data[31:16] == 16'hF000 && intx_in == 4'h0)
        |=> (rd_data[31:16] == 16'h0000));

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15] == 1'b0 && rd_data[7:4] == 4'h0));
endmodule

bind intx_ctl_reg intx_ctl_reg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .intx_in (intx_in),
    .err_in  (err_in),
    .rd_data (rd_data),
    .irq_out (irq_out)
);

// File: tb/intx_ctl_reg_tb.sv
// Bench: behavioural model updated at each rising edge, compared at each falling edge.
module intx_ctl_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CFG_BITS = 32'h0FFF_7F0F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [3:0]  wr_be;
    logic [31:0] wr_data;
    logic [3:0]  intx_in;
    logic [7:0]  err_in;
    logic [31:0] rd_data;
    logic        irq_out;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    started = 1'b0;
    bit    done = 1'b0;

    logic [31:0] m_cfg;
    logic [3:0]  m_sts;
    logic [3:0]  m_clr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intx_ctl_reg u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_be (wr_be),
        .wr_data (wr_data), .intx_in (intx_in), .err_in (err_in),
        .rd_data (rd_data), .irq_out (irq_out)
    );

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_cfg = 32'h0;
            m_sts = 4'h0;
        end else begin
            m_clr = 4'h0;
            if (wr_en) begin
                for (int b = 0; b < 4; b++) begin
                    if (wr_be[b]) begin
                        for (int k = 0; k < 8; k++) begin
                            if (CFG_BITS[8*b+k]) m_cfg[8*b+k] = wr_data[8*b+k];
                            if (8*b+k >= 28 && wr_data[8*b+k]) m_clr[8*b+k-28] = 1'b1;
                        end
                    end
                end
            end
            m_sts = (m_sts & ~m_clr) | intx_in;
        end
    end

    // Compare both outputs with the model every cycle.
    always @(negedge clk) begin
        if (started && !done) begin
            logic [31:0] exp_rd;
            logic        exp_irq;
            exp_rd  = {m_sts, 28'h0} | m_cfg;
            exp_irq = (|(m_sts & m_cfg[25:22])) || (|(err_in & {m_cfg[27:26], m_cfg[21:16]}));
            checks++;
            if (rd_data !== exp_rd) begin
                failures++;
                $display("FAIL %s rd_data actual=%h expected=%h t=%0t", cur_req, rd_data, exp_rd, $time);
            end
            checks++;
            if (irq_out !== exp_irq) begin
                failures++;
                $display("FAIL %s irq_out actual=%b expected=%b t=%0t", cur_req, irq_out, exp_irq, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_be = 4'h0; wr_data = 32'h0;
    endtask

    // Named directed check on masked register bits, taken at the next falling edge.
    task automatic expect_rd(input logic [31:0] mask, input logic [31:0] val, input string tag);
        @(negedge clk);
        checks++;
        if ((rd_data & mask) !== (val & mask)) begin
            failures++;
            $display("FAIL %s masked rd_data actual=%h expected=%h", tag, rd_data & mask, val & mask);
        end
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b1; wr_be = 4'hF; wr_data = 32'hFFFF_FFFF;
        intx_in = 4'hF; err_in = 8'hFF;
        // R1: reset wins over writes and inputs
        step(3);
        wr_en = 1'b0; wr_be = 4'h0; wr_data = 32'h0; intx_in = 4'h0; err_in = 8'h0;
        step(1);
        expect_rd(32'hFFFF_FFFF, 32'h0, "R1");
        rst_n = 1'b1;
        step(1);

        // R2: capture with all enables off, no request
        cur_req = "R2";
        intx_in = 4'b0001; step(1); intx_in = 4'h0;
        expect_rd(32'hF000_0000, 32'h1000_0000, "R2");
        intx_in = 4'b1010; step(1); intx_in = 4'h0;
        expect_rd(32'hF000_0000, 32'hB000_0000, "R2");

        // R3: clear line A only, zeros leave others
        cur_req = "R3";
        wr(4'b1000, 32'h1000_0000);
        expect_rd(32'hF000_0000, 32'hA000_0000, "R3");
        wr(4'b1000, 32'h0000_0000);
        expect_rd(32'hF000_0000, 32'hA000_0000, "R3");

        // R5: enable lines and observe the request
        cur_req = "R5";
        wr(4'b0100, 32'h0040_0000);
        step(2);
        wr(4'b1100, 32'h0240_0000);
        step(2);
        wr(4'b1000, 32'hA000_0000);
        step(2);

        // R4: clear while the input stays high
        cur_req = "R4";
        intx_in = 4'b0100; step(1);
        wr(4'b1000, 32'h4000_0000);
        expect_rd(32'h4000_0000, 32'h4000_0000, "R4");
        intx_in = 4'h0;
        wr(4'b1000, 32'h4000_0000);
        expect_rd(32'h4000_0000, 32'h0, "R4");

        // R6: error enables and same-cycle request
        cur_req = "R6";
        wr(4'b1100, 32'h0800_0000);
        err_in = 8'b1000_0000; step(2);
        err_in = 8'b0100_0000; step(2);
        wr(4'b1100, 32'h0005_0000);
        err_in = 8'b0000_0100; step(1);
        err_in = 8'b0000_0010; step(1);
        err_in = 8'b0000_0001; step(1);
        err_in = 8'h0; step(1);

        // R7: lane selection and idle stability
        cur_req = "R7";
        wr(4'b0001, 32'hFFFF_FFFF);
        expect_rd(32'h0FFF_FFFF, 32'h0005_000F, "R7");
        wr_en = 1'b0; wr_be = 4'hF; wr_data = 32'h0; step(2); wr_be = 4'h0;
        expect_rd(32'h0FFF_FFFF, 32'h0005_000F, "R7");

        // R9: stored settings with no effect on the request
        cur_req = "R9";
        wr(4'b0011, 32'h0000_7F0A);
        expect_rd(32'h0000_7F0F, 32'h0000_7F0A, "R9");
        err_in = 8'h02; step(2); err_in = 8'h0; step(1);

        // R10: reserved bits read zero after an all-ones write
        cur_req = "R10";
        wr(4'b1111, 32'hFFFF_FFFF);
        expect_rd(32'h0000_80F0, 32'h0, "R10");

        // R8: halfword clear of pending and enables
        cur_req = "R8";
        intx_in = 4'hF; step(1); intx_in = 4'h0;
        wr(4'b1100, 32'hF000_0000);
        expect_rd(32'hFFFF_0000, 32'h0, "R8");
        expect_rd(32'h0000_7F0F, 32'h0000_7F0F, "R8");

        // R7: random mix of writes and inputs, compared each cycle
        cur_req = "R7";
        for (int i = 0; i < 600; i++) begin
            wr_en   = ($urandom % 3) == 0;
            wr_be   = 4'($urandom);
            wr_data = $urandom;
            intx_in = 4'($urandom) & 4'($urandom);
            err_in  = 8'($urandom) & 8'($urandom);
            step(1);
        end
        wr_en = 1'b0; intx_in = 4'h0; err_in = 8'h0;

        // R1: reset in mid-run
        cur_req = "R1";
        rst_n = 1'b0; step(1); rst_n = 1'b1;
        expect_rd(32'hFFFF_FFFF, 32'h0, "R1");
        step(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule